// File: doc/BRIEF.md
# Sector Write Buffer With Inactivity Commit

This block is a clocked model of the write-side control of a byte-wide nonvolatile memory that is programmed one whole 256-byte sector at a time. A host drives three asynchronous active-low strobes: select, read enable and write enable. It also drives a 19-bit address and an 8-bit write bus. Each byte load goes into a page buffer. When the strobes have been quiet for a set number of clock cycles, the load period closes. The buffered sector is then committed to a backing array after a fixed programming period.

All three strobes pass through two-flop synchronizers before any edge is detected. A load is accepted on the falling edge of the combined write condition: select low, write enable low and read enable high. The address is captured when that condition is entered and the data when it is left. The first accepted load fixes the sector for the load period. While programming is under way, a read returns a polling value in place of array data.

The backing array stores 2^ARR_SEC_W sectors. The upper sector address bits alias onto them.

Top module: `sector_prog_ctrl`

## Requirements
- R1: With sel_n low, rden_n low and wren_n high, rdata_oe is 1 in the same cycle. Outside programming, rdata holds the array byte at addr.
- R2: rdata_oe is 0 whenever sel_n or rden_n is high, and whenever wren_n is low.
- R3: A byte load is a low pulse on wren_n while sel_n is low, or a low pulse on sel_n while wren_n is low, with rden_n high in both cases. After the commit, the loaded byte reads back.
- R4: addr[18:8] selects the sector and addr[7:0] the byte within it. Bytes may be loaded in any order, and a byte loaded twice keeps its last value.
- R5: The first load of a period fixes the sector. A later load in that period with a different addr[18:8] changes neither the buffer nor the poll value.
- R6: The load period ends, and busy rises, TIMEOUT_CYC cycles after the write strobe was last active. No strobe may arrive in that time.
- R7: After the commit, every byte of the sector that was not loaded in the period reads FFh, including bytes written by an earlier commit. Other sectors are unchanged.
- R8: While busy is 1, a read returns the last accepted byte with bit 7 inverted and bits 6:0 unchanged. After busy falls, reads return array data.
- R9: busy stays 1 for exactly PROG_CYC cycles. The array holds the new sector once busy has fallen.
- R10: Byte loads while busy is 1 change neither the commit nor the array, and they do not open a new load period.
- R11: After reset, busy is 0 and every array byte reads FFh.
- R12: A write strobe with rden_n low is not a byte load. It opens no load period and changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| rden_n | input | 1 | Read enable, active low, asynchronous |
| wren_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 19 | Sector (18:8) and byte (7:0) address |
| wdata | input | 8 | Write data bus |
| rdata | output | 8 | Read data or polling value |
| rdata_oe | output | 1 | Output drive enable for rdata |
| busy | output | 1 | High from the end of the load period until the commit completes |

## Verification
Read decoding is combinational, so rdata and rdata_oe are sampled a quarter period after the pins change, within the same cycle. A strobe edge reaches the control logic after three clock edges: two synchronizer stages and one edge register. The bench therefore holds the address and data for five cycles after each strobe. It expects busy to rise TIMEOUT_CYC+3 edges after the final strobe pin change. A monitor counts how many falling clock edges busy stays high and compares the count with PROG_CYC. Array contents are read back only after busy has fallen, and the poll value is read in the cycle after busy is first seen high.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_ADDR_W = 19;
  localparam int SP_OFS_W  = 8;
  localparam int SP_DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } sp_state_e;
endpackage

// File: rtl/sp_strobe_sync.sv
module sp_strobe_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  // inactive (high) level after reset on every strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '1;
      stg2_q <= '1;
    end else begin
      stg1_q <= raw;
      stg2_q <= stg1_q;
    end
  end

  assign sync = stg2_q;
endmodule

// File: rtl/sp_page_buf.sv
module sp_page_buf #(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8,
  localparam int BYTES = 1 << OFS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         first,
  input  logic [OFS_W-1:0]             idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [BYTES-1:0][DATA_W-1:0] data,
  output logic [BYTES-1:0]             mask
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic hit;
    assign hit = wr_en && (idx == OFS_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[i] <= '0;
        mask[i] <= 1'b0;
      end else if (hit) begin
        data[i] <= wdata;
        mask[i] <= 1'b1;
      end else if (first) begin
        mask[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sp_sector_array.sv
module sp_sector_array #(
  parameter int OFS_W     = 8,
  parameter int DATA_W    = 8,
  parameter int ARR_SEC_W = 3,
  localparam int BYTES    = 1 << OFS_W,
  localparam int SECS     = 1 << ARR_SEC_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ARR_SEC_W-1:0]         csec,
  input  logic [BYTES-1:0][DATA_W-1:0] cdata,
  input  logic [BYTES-1:0]             cmask,
  input  logic [ARR_SEC_W-1:0]         rsec,
  input  logic [OFS_W-1:0]             rbyte,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] mem [SECS][BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SECS; s++) begin
        for (int b = 0; b < BYTES; b++) begin
          mem[s][b] <= '1;
        end
      end
    end else if (commit) begin
      for (int b = 0; b < BYTES; b++) begin
        mem[csec][b] <= cmask[b] ? cdata[b] : '1;
      end
    end
  end

  assign rdata = mem[rsec][rbyte];
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import sp_pkg::*;
#(
  parameter int ADDR_W      = SP_ADDR_W,
  parameter int OFS_W       = SP_OFS_W,
  parameter int DATA_W      = SP_DATA_W,
  parameter int ARR_SEC_W   = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter int PROG_CYC    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rden_n,
  input  logic              wren_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              busy
);
  localparam int SEC_W   = ADDR_W - OFS_W;
  localparam int BYTES   = 1 << OFS_W;
  localparam int CNT_MAX = (TIMEOUT_CYC > PROG_CYC) ? TIMEOUT_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // strobe synchronization and write-condition edges
  logic [2:0] pins_s;
  logic       wr_s, wr_q, wr_rise, wr_fall;

  sp_strobe_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({sel_n, rden_n, wren_n}),
    .sync (pins_s)
  );

  assign wr_s    = ~pins_s[2] & pins_s[1] & ~pins_s[0];
  assign wr_rise = wr_s & ~wr_q;
  assign wr_fall = ~wr_s & wr_q;

  // state registers
  sp_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SEC_W-1:0]    sec_q, sec_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   last_q, last_d;
  logic                buf_we, buf_first, commit;
  logic                sec_match;

  assign sec_match = (addr_q[ADDR_W-1:OFS_W] == sec_q);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sec_d     = sec_q;
    last_d    = last_q;
    buf_we    = 1'b0;
    buf_first = 1'b0;
    commit    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_fall) begin
          state_d   = ST_LOAD;
          sec_d     = addr_q[ADDR_W-1:OFS_W];
          last_d    = wdata;
          buf_we    = 1'b1;
          buf_first = 1'b1;
          cnt_d     = '0;
        end
      end
      ST_LOAD: begin
        if (wr_s) begin
          cnt_d = '0;
        end else if (wr_fall && sec_match) begin
          last_d = wdata;
          buf_we = 1'b1;
          cnt_d  = '0;
        end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
          state_d = ST_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          commit  = 1'b1;
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sec_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sec_q   <= sec_d;
      last_q  <= last_d;
      wr_q    <= wr_s;
    end
  end

  // address capture when the write condition is entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_rise) begin
      addr_q <= addr;
    end
  end

  // page buffer and backing array
  logic [BYTES-1:0][DATA_W-1:0] buf_data;
  logic [BYTES-1:0]             buf_mask;
  logic [DATA_W-1:0]            arr_rd;

  sp_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(buf_we),
    .first(buf_first),
    .idx  (addr_q[OFS_W-1:0]),
    .wdata(wdata),
    .data (buf_data),
    .mask (buf_mask)
  );

  sp_sector_array #(.OFS_W(OFS_W), .DATA_W(DATA_W), .ARR_SEC_W(ARR_SEC_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit),
    .csec  (sec_q[ARR_SEC_W-1:0]),
    .cdata (buf_data),
    .cmask (buf_mask),
    .rsec  (addr[OFS_W+ARR_SEC_W-1:OFS_W]),
    .rbyte (addr[OFS_W-1:0]),
    .rdata (arr_rd)
  );

  // read path: direct from pins, poll value while programming
  logic              prog;
  logic [DATA_W-1:0] poll_val;

  assign prog     = (state_q == ST_PROG);
  assign poll_val = {~last_q[DATA_W-1], last_q[DATA_W-2:0]};
  assign rdata_oe = ~sel_n & ~rden_n & wren_n;
  assign rdata    = !rdata_oe ? '0 : (prog ? poll_val : arr_rd);
  assign busy     = prog;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int TIMEOUT_CYC = 64,
  parameter int PROG_CYC    = 100,
  parameter int BYTES       = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             rden_n,
  input logic             wren_n,
  input logic             rdata_oe,
  input logic             busy,
  input logic             wr_s,
  input logic [BYTES-1:0] mask
);
  logic [31:0] quiet_cnt;
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      busy_cnt  <= '0;
    end else begin
      if (wr_s) begin
        quiet_cnt <= '0;
      end else if (quiet_cnt != '1) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end
  end

  AST_NO_DRIVE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || rden_n) |-> !rdata_oe); // R2
  AST_NO_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wren_n |-> !rdata_oe); // R2
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (quiet_cnt >= 32'(TIMEOUT_CYC))); // R6
  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(PROG_CYC))); // R9
  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask)); // R10
endmodule

bind sector_prog_ctrl sp_checker #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .PROG_CYC   (PROG_CYC),
  .BYTES      (BYTES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .rden_n  (rden_n),
  .wren_n  (wren_n),
  .rdata_oe(rdata_oe),
  .busy    (busy),
  .wr_s    (wr_s),
  .mask    (buf_mask)
);

// File: tb/sector_prog_ctrl_test.sv
module sector_prog_ctrl_test;
  localparam int CLK_P = 10;
  localparam int TO    = 64;
  localparam int PC    = 100;

  logic        clk;
  logic        rst_n;
  logic        sel_n, rden_n, wren_n;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic        busy;

  sector_prog_ctrl #(.TIMEOUT_CYC(TO), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rden_n(rden_n), .wren_n(wren_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  // reference model
  logic [7:0]  ref_mem [8][256];
  logic [7:0]  pend_data [256];
  bit          pend_mask [256];
  bit          pend_act;
  logic [10:0] pend_sec;
  logic [7:0]  pend_last;

  // busy run-length monitor
  int run_len  = 0;
  int last_run = 0;
  always @(negedge clk) begin
    if (busy) run_len++;
    else begin
      if (run_len != 0) last_run = run_len;
      run_len = 0;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [18:0] a);
    return ref_mem[a[10:8]][a[7:0]];
  endfunction

  function automatic logic [7:0] poll_of(input logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_load(input logic [18:0] a, input logic [7:0] d);
    if (!pend_act) begin
      pend_act = 1;
      pend_sec = a[18:8];
      for (int i = 0; i < 256; i++) pend_mask[i] = 0;
    end
    if (a[18:8] == pend_sec) begin
      pend_mask[a[7:0]] = 1;
      pend_data[a[7:0]] = d;
      pend_last = d;
    end
  endtask

  task automatic model_commit();
    for (int i = 0; i < 256; i++)
      ref_mem[pend_sec[2:0]][i] = pend_mask[i] ? pend_data[i] : 8'hFF;
    pend_act = 0;
  endtask

  // byte load pin sequence; by_sel picks the strobe that is pulsed
  task automatic pin_load(input logic [18:0] a, input logic [7:0] d, input bit by_sel);
    @(negedge clk);
    addr = a; wdata = d; rden_n = 1'b1;
    if (!by_sel) begin
      sel_n = 1'b0;
      repeat (2) @(negedge clk);
      wren_n = 1'b0;
      repeat (4) @(negedge clk);
      wren_n = 1'b1;
      repeat (5) @(negedge clk);
      sel_n = 1'b1;
    end else begin
      wren_n = 1'b0;
      repeat (2) @(negedge clk);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      sel_n = 1'b1;
      repeat (5) @(negedge clk);
      wren_n = 1'b1;
    end
  endtask

  task automatic load_byte(input logic [18:0] a, input logic [7:0] d, input bit by_sel);
    pin_load(a, d, by_sel);
    model_load(a, d);
  endtask

  task automatic read_chk(input logic [18:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rden_n = 1'b0; wren_n = 1'b1;
    #(CLK_P/4);
    check(rdata_oe === 1'b1, "R1 drive", int'(rdata_oe), 1);
    check(rdata === exp, req, int'(rdata), int'(exp));
    @(negedge clk);
    sel_n = 1'b1; rden_n = 1'b1;
  endtask

  task automatic read_sector(input logic [10:0] sec, input string req);
    for (int b = 0; b < 256; b++) read_chk({sec, 8'(b)}, exp_byte({sec, 8'(b)}), req);
  endtask

  // wait for the load period to close and the commit to finish
  task automatic wait_commit(input bit inject);
    int cnt = 0;
    while (!busy && cnt < TO + 20) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt >= TO - 3 && cnt <= TO - 1, "R6 timeout", cnt, TO - 2);
    read_chk(19'd0 | {pend_sec, 8'h00}, poll_of(pend_last), "R8 poll");
    if (inject) pin_load({pend_sec, 8'h00}, ~pend_data[0], 1'b0); // R10 stimulus
    cnt = 0;
    while (busy && cnt < PC + 20) begin
      @(negedge clk);
      cnt++;
    end
    @(negedge clk);
    check(last_run == PC, "R9 busy length", last_run, PC);
    model_commit();
    if (inject) begin
      repeat (TO + 10) @(negedge clk);
      check(busy == 1'b0, "R10 no new period", int'(busy), 0);
    end
  endtask

  initial begin
    int seed_tmp;
    seed_tmp = $urandom(32'd4711);
    rst_n = 1'b0; sel_n = 1'b1; rden_n = 1'b1; wren_n = 1'b1;
    addr = '0; wdata = '0; pend_act = 0; pend_sec = '0; pend_last = '0;
    for (int s = 0; s < 8; s++) for (int b = 0; b < 256; b++) ref_mem[s][b] = 8'hFF;
    for (int b = 0; b < 256; b++) begin pend_data[b] = '0; pend_mask[b] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(busy == 1'b0, "R11 busy", int'(busy), 0);
    check(rdata_oe == 1'b0, "R11 idle oe", int'(rdata_oe), 0);
    read_chk(19'h00000, 8'hFF, "R11 erased");
    read_chk(19'h7FFFF, 8'hFF, "R11 erased");

    // R2 output drive gating
    @(negedge clk); sel_n = 1'b1; rden_n = 1'b0; wren_n = 1'b1; #(CLK_P/4);
    check(rdata_oe == 1'b0, "R2 deselected", int'(rdata_oe), 0);
    @(negedge clk); sel_n = 1'b0; rden_n = 1'b1; #(CLK_P/4);
    check(rdata_oe == 1'b0, "R2 read disabled", int'(rdata_oe), 0);
    @(negedge clk); sel_n = 1'b0; rden_n = 1'b0; wren_n = 1'b0; #(CLK_P/4);
    check(rdata_oe == 1'b0, "R2 write low", int'(rdata_oe), 0);
    @(negedge clk); sel_n = 1'b1; rden_n = 1'b1; wren_n = 1'b1;
    repeat (TO + 10) @(negedge clk);
    check(busy == 1'b0, "R12 oe-low strobe no period", int'(busy), 0);

    // R3 R4 directed: two bytes out of order, both strobe styles
    load_byte({11'h005, 8'h10}, 8'hA5, 1'b0);
    load_byte({11'h005, 8'h03}, 8'h3C, 1'b1);
    load_byte({11'h005, 8'h10}, 8'h5A, 1'b0);
    wait_commit(1'b0);
    read_chk({11'h005, 8'h10}, 8'h5A, "R4 last write wins");
    read_chk({11'h005, 8'h03}, 8'h3C, "R3 loaded byte");
    read_sector(11'h005, "R7 unloaded FF");
    read_chk({11'h004, 8'h10}, 8'hFF, "R7 other sector");

    // R7 reprogram with one byte: previous bytes erased
    load_byte({11'h005, 8'h80}, 8'h01, 1'b1);
    wait_commit(1'b0);
    read_chk({11'h005, 8'h10}, 8'hFF, "R7 replaced sector");
    read_chk({11'h005, 8'h80}, 8'h01, "R3 reload byte");

    // R5 mismatched sector ignored, poll value from last accepted byte
    load_byte({11'h002, 8'h00}, 8'h11, 1'b0);
    load_byte({11'h003, 8'h01}, 8'hF2, 1'b0);
    load_byte({11'h002, 8'h02}, 8'h33, 1'b1);
    load_byte({11'h003, 8'h04}, 8'h94, 1'b1);
    wait_commit(1'b0);
    read_chk({11'h002, 8'h01}, 8'hFF, "R5 ignored byte");
    read_chk({11'h003, 8'h01}, 8'hFF, "R5 other sector untouched");
    read_sector(11'h002, "R5 sector data");

    // R10 load during programming
    load_byte({11'h006, 8'h00}, 8'h77, 1'b0);
    load_byte({11'h006, 8'h05}, 8'hC8, 1'b0);
    wait_commit(1'b1);
    read_chk({11'h006, 8'h00}, 8'h77, "R10 ignored load");
    read_sector(11'h006, "R10 sector data");

    // R12 write strobe with read enable low
    @(negedge clk);
    addr = {11'h006, 8'h05}; wdata = 8'h00; sel_n = 1'b0; rden_n = 1'b0; wren_n = 1'b0;
    repeat (4) @(negedge clk);
    wren_n = 1'b1;
    repeat (3) @(negedge clk);
    sel_n = 1'b1; rden_n = 1'b1;
    repeat (TO + 10) @(negedge clk);
    check(busy == 1'b0, "R12 no period", int'(busy), 0);
    read_chk({11'h006, 8'h05}, 8'hC8, "R12 data unchanged");

    // random rounds
    for (int r = 0; r < 6; r++) begin
      logic [10:0] sec;
      int n;
      sec = (r == 3) ? pend_sec : 11'($urandom);
      n = 1 + int'($urandom % 24);
      for (int k = 0; k < n; k++)
        load_byte({sec, 8'($urandom)}, 8'($urandom), 1'($urandom));
      wait_commit(1'b0);
      read_sector(sec, "R4 random sector");
    end

    // full sector, descending order
    for (int b = 255; b >= 0; b--) load_byte({11'h001, 8'(b)}, 8'(b ^ 8'h5C), 1'(b));
    wait_commit(1'b0);
    read_sector(11'h001, "R3 full sector");
    read_sector(11'h005, "R7 earlier sector kept");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule